// File: doc/BRIEF.md
# Periodic Reload Down-Counter with Register Window

This block is a 16-bit down-counter reached through a simple synchronous register port. The port has an address, a write strobe, write data and read data, and it decodes a 256-byte window. A prescaler divides the system clock down to a 1 MHz tick. Once software starts the counter, each tick lowers the count by one. The tick after the count reaches zero refills it from the reload register, so the counter runs as a periodic timer.

Software controls the counter with three word registers. The control register at offset 0x00 holds a start bit at bit 0 and a soft-reset bit at bit 31. The reload register at offset 0x08 holds the period. The count register at offset 0x0C returns the live value. A write to the reload register refills the live count at once. Clearing the start bit does not stop a running counter. Only a hardware reset or a soft reset stops it.

Top module: `reload_timer`

## Requirements
- R1: After reset, reading offsets 0x00, 0x08 and 0x0C returns 0, and the counter stays stopped.
- R2: A write to offset 0x00 with bit 31 set clears the control register, the reload register and the count, and stops the counter. The written value is not stored, and bit 0 in the same write does not start the counter.
- R3: A write to offset 0x00 with bit 0 set and bit 31 clear stores the full 32-bit value, starts the counter and restarts the prescaler phase.
- R4: A write to offset 0x00 with bits 0 and 31 both clear stores the value and leaves a running counter running with its phase unchanged.
- R5: A write to offset 0x08 stores write-data bits 15:0 (upper bits read as 0), loads that value into the live count in the same edge, and restarts the prescaler phase.
- R6: Offset 0x0C reads the count zero-extended to 32 bits. A write to 0x0C changes nothing.
- R7: While running, the count drops by one on every PRESCALE-th clock edge after the last phase restart, where PRESCALE = CLK_HZ/1_000_000.
- R8: On a tick with the count at 0, the count is refilled from the reload register. With a reload value of 0, the count stays 0.
- R9: While stopped, the count holds its value.
- R10: Any offset other than 0x00, 0x08 and 0x0C reads 0, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A wrong count, reload or run flag shows up at the count readback no later than one prescaler period. The count either misses its step or steps when it should hold. An error in the control or reload register shows on the very next read of that offset. An error in the prescaler phase moves each decrement by a few cycles. The bench therefore sweeps the wait after each start one cycle at a time, over several reload values, so that a single-cycle error in the phase changes the value read back.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int TICK_HZ  = 1_000_000;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h0C;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_SRST_BIT  = 31;
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run & ~restart;
    end else begin : g_div
      logic [PW-1:0] phase_q, phase_d;
      logic          last;

      assign last = (phase_q == PW'(PRESCALE - 1));

      always_comb begin
        phase_d = phase_q;
        if (restart)  phase_d = '0;
        else if (run) phase_d = last ? '0 : phase_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end

      assign tick = run & last & ~restart;
    end
  endgenerate
endmodule

// File: rtl/rt_regfile.sv
module rt_regfile
  import rt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              soft_rst,
  output logic              start,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  reload_q
);
  logic              wr_ctrl;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_d;

  assign wr_ctrl  = bus_we && (bus_addr == OFF_CTRL);
  assign soft_rst = wr_ctrl && bus_wdata[CTRL_SRST_BIT];
  assign start    = wr_ctrl && !bus_wdata[CTRL_SRST_BIT] && bus_wdata[CTRL_START_BIT];
  assign load     = bus_we && (bus_addr == OFF_RELOAD);
  assign load_val = bus_wdata[CNT_W-1:0];

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (soft_rst) begin
      ctrl_d   = '0;
      reload_d = '0;
    end else begin
      if (wr_ctrl) ctrl_d   = bus_wdata;
      if (load)    reload_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:   bus_rdata = ctrl_q;
      OFF_RELOAD: bus_rdata = DATA_W'(reload_q);
      OFF_COUNT:  bus_rdata = DATA_W'(count);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_q,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q
);
  logic [CNT_W-1:0] count_d;
  logic             run_d;

  always_comb begin
    run_d   = run_q;
    count_d = count_q;
    if (soft_rst) begin
      run_d   = 1'b0;
      count_d = '0;
    end else begin
      if (start) run_d = 1'b1;
      if (load)
        count_d = load_val;
      else if (tick)
        count_d = (count_q == '0) ? reload_q : count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else begin
      run_q   <= run_d;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int CLK_HZ = 4_000_000,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PRESCALE = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic             rst_sync_n;
  logic             soft_rst, start, load, tick, run_q, restart;
  logic [CNT_W-1:0] load_val, reload_q, count_q;

  assign restart = soft_rst | start | load;

  rt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rt_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .count     (count_q),
    .bus_rdata (bus_rdata),
    .soft_rst  (soft_rst),
    .start     (start),
    .load      (load),
    .load_val  (load_val),
    .reload_q  (reload_q)
  );

  rt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run_q),
    .restart (restart),
    .tick    (tick)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst),
    .start    (start),
    .load     (load),
    .load_val (load_val),
    .reload_q (reload_q),
    .tick     (tick),
    .count_q  (count_q),
    .run_q    (run_q)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              running,
  input logic              tick
);
  logic reg_wr;
  logic known;
  assign reg_wr = bus_we && (bus_addr == OFF_CTRL || bus_addr == OFF_RELOAD);
  assign known  = (bus_addr == OFF_CTRL) || (bus_addr == OFF_RELOAD) || (bus_addr == OFF_COUNT);

  assert_soft_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CTRL && bus_wdata[CTRL_SRST_BIT])
    |=> (count == '0 && reload == '0 && !running));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CTRL && !bus_wdata[CTRL_SRST_BIT] && bus_wdata[CTRL_START_BIT])
    |=> running);

  assert_keep_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(bus_we && bus_addr == OFF_CTRL && bus_wdata[CTRL_SRST_BIT])) |=> running);

  assert_reload_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_RELOAD)
    |=> (count == $past(bus_wdata[CNT_W-1:0]) && reload == $past(bus_wdata[CNT_W-1:0])));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reg_wr && count != '0) |=> (count == $past(count) - 1'b1));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reg_wr && count == '0) |=> (count == $past(reload)));

  assert_no_tick_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);

  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reg_wr) |=> $stable(count));

  assert_unknown_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (bus_rdata == '0));
endmodule

bind reload_timer rt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .count     (count_q),
  .reload    (reload_q),
  .running   (run_q),
  .tick      (tick)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int P          = CLK_HZ / 1_000_000;
  localparam logic [7:0] A_CTRL = 8'h00, A_REL = 8'h08, A_CNT = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  reload_timer #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_cnt(int c0, int r, int n);
    int m;
    if (n <= c0) return c0 - n;
    m = n - c0 - 1;
    if (r == 0) return 0;
    return r - (m % (r + 1));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int rlist[6];
    rlist = '{0, 1, 2, 3, 6, 65535};
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, and stopped (count holds)
    rd_check("R1 ctrl", A_CTRL, 0);
    rd_check("R1 reload", A_REL, 0);
    rd_check("R1 count", A_CNT, 0);
    repeat (3*P) @(negedge clk);
    rd_check("R1 stopped", A_CNT, 0);

    // R7/R8: sweep reload values and wait lengths after start
    foreach (rlist[i]) begin
      int r = rlist[i];
      int jmax = (r > 8) ? 24 : 2*P*(r+1) + P + 1;
      for (int j = 0; j <= jmax; j++) begin
        wr(A_CTRL, 32'h8000_0000);
        wr(A_REL, r);
        wr(A_CTRL, 32'h0000_0001);
        repeat (j) @(negedge clk);
        rd_check((r == 0) ? "R8 zero reload" : "R7 R8 periodic count",
                 A_CNT, exp_cnt(r, r, j / P));
      end
    end

    // R3: full value stored
    wr(A_CTRL, 32'h8000_0000);
    wr(A_CTRL, 32'h5A5A_0001);
    rd_check("R3 ctrl readback", A_CTRL, 32'h5A5A_0001);

    // R4: clearing start bit keeps counter running, phase unchanged
    wr(A_CTRL, 32'h8000_0000);
    wr(A_REL, 9);
    wr(A_CTRL, 32'h0000_0001);
    wr(A_CTRL, 32'h0000_0010);
    repeat (2*P + 1) @(negedge clk);
    rd_check("R4 still running", A_CNT, 7);
    rd_check("R4 ctrl stored", A_CTRL, 32'h0000_0010);

    // R5: reload while running reloads live count and restarts phase
    wr(A_CTRL, 32'h8000_0000);
    wr(A_REL, 3);
    wr(A_CTRL, 32'h0000_0001);
    repeat (2*P + 1) @(negedge clk);
    rd_check("R5 pre", A_CNT, 1);
    wr(A_REL, 32'hABCD_000A);
    rd_check("R5 immediate load", A_CNT, 10);
    rd_check("R5 16-bit field", A_REL, 32'h0000_000A);
    repeat (P - 1) @(negedge clk);
    rd_check("R5 phase restart", A_CNT, 10);
    @(negedge clk);
    rd_check("R5 first tick", A_CNT, 9);

    // R6: count write ignored (running)
    wr(A_CTRL, 32'h8000_0000);
    wr(A_REL, 20);
    wr(A_CTRL, 32'h0000_0001);
    wr(A_CNT, 32'h0000_1234);
    repeat (P - 1) @(negedge clk);
    rd_check("R6 write ignored running", A_CNT, 19);

    // R9 + R6: stopped holds, count write ignored
    wr(A_CTRL, 32'h8000_0000);
    wr(A_REL, 32'h0001_2345);
    repeat (10*P) @(negedge clk);
    rd_check("R9 hold stopped", A_CNT, 32'h0000_2345);
    wr(A_CNT, 32'h0000_0077);
    rd_check("R6 write ignored stopped", A_CNT, 32'h0000_2345);

    // R2: soft reset with start bit while running
    wr(A_CTRL, 32'h0000_0001);
    repeat (2*P) @(negedge clk);
    wr(A_CTRL, 32'h8000_0001);
    rd_check("R2 ctrl cleared", A_CTRL, 0);
    rd_check("R2 reload cleared", A_REL, 0);
    rd_check("R2 count cleared", A_CNT, 0);
    wr(A_REL, 4);
    repeat (3*P) @(negedge clk);
    rd_check("R2 not started", A_CNT, 4);

    // R10: unknown offsets
    rd_check("R10 read 0x04", 8'h04, 0);
    rd_check("R10 read 0x01", 8'h01, 0);
    rd_check("R10 read 0x10", 8'h10, 0);
    rd_check("R10 read 0xFC", 8'hFC, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd_check("R10 ctrl untouched", A_CTRL, 0);
    rd_check("R10 reload untouched", A_REL, 4);
    repeat (2*P) @(negedge clk);
    rd_check("R10 count untouched", A_CNT, 4);

    done = 1;
    finish_run();
  end
endmodule